// File: doc/BRIEF.md
# Least-in-flight fetch thread selector

This block decides, cycle by cycle, which of four hardware threads feeds a shared fetch stage in a simultaneous multithreaded out-of-order core. Each thread has its own program counter upstream, and instructions from several threads travel through the pipeline together. The selector keeps one in-flight counter per thread. The counter goes up by the number of instructions that thread fetched and goes down by the number it committed and squashed. Each cycle, fetch goes to the eligible thread with the fewest instructions in flight.

A thread is eligible when it is active, not stalled and under its occupancy cap. While two or more threads are active, the cap is the shared queue depth divided by the number of active threads, so no thread can fill the whole queue. A lone active thread has no cap and can use the whole machine. Equal counts are broken in rotating order. The search starts at a pointer that moves to the thread after the last winner.

A sharing-mode selector drives the cap logic through three named modes. MODE_IDLE applies when no thread is active, and no thread is eligible. MODE_SOLO applies when exactly one thread is active, and the cap is lifted. MODE_SHARED applies when two or more threads are active, and the cap is enforced. The block moves straight between modes as the active count changes: IDLE to SOLO when one thread wakes, SOLO to SHARED when a second wakes, and back the same way.

Top module: `fts_fetch_sel`

## Requirements
- R1: After reset every in-flight count is zero and the rotation pointer is at thread 0, so with all threads active and unstalled thread 0 is granted first.
- R2: Each thread's count takes the value count + fetch − commit − squash at the next clock edge, where each of the three per-thread fields is 3 bits wide at bit offset 3·thread.
- R3: A count never goes below zero (a larger decrement clamps to 0) and never above 127 (a larger increment holds at 127).
- R4: When a grant is given, it goes to the eligible thread with the smallest count.
- R5: Among eligible threads with equal smallest counts, the grant goes to the first one met when searching upward and circularly from the rotation pointer. After each grant the pointer moves to the granted thread plus one, modulo 4.
- R6: An inactive or stalled thread is never granted, and the other eligible threads are still served.
- R7: With n ≥ 2 active threads, a thread whose count is at least floor(64 / n) is not eligible.
- R8: With exactly one active thread, the cap does not apply, and that thread is granted whenever it is unstalled.
- R9: When no thread is eligible, fetch_grant_valid is 0 and fetch_grant is all zero.
- R10: fetch_grant is one-hot or zero, and fetch_grant_valid is 1 exactly when a grant bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_cnt | input | 12 | Instructions fetched this cycle, 3 bits per thread |
| commit_cnt | input | 12 | Instructions committed this cycle, 3 bits per thread |
| squash_cnt | input | 12 | Instructions squashed this cycle, 3 bits per thread |
| thread_active | input | 4 | Thread has a running context |
| thread_stalled | input | 4 | Thread cannot fetch this cycle |
| fetch_grant | output | 4 | One-hot thread chosen for fetch |
| fetch_grant_valid | output | 1 | A thread was chosen |

## Verification
The grant is combinational in the same cycle from the active and stalled inputs, the registered counts and the registered pointer. A change to fetch, commit or squash counts, or a grant, affects the grant only after the next rising edge. The bench drives inputs on the falling edge and compares outputs 2 ns later, still before the rising edge. At that rising edge it updates its behavioural model of counts and pointer, so every comparison uses state that was one edge old in both the model and the design. Directed phases drive the tie rotation, stalls, the cap in shared mode, solo saturation and clamped draining, and a random phase follows them.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_SOLO,
        MODE_SHARED
    } share_mode_e;
endpackage

// File: rtl/fts_inflight_ctr.sv
`timescale 1ns/1ps
module fts_inflight_ctr #(
    parameter int CNT_W  = 7,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] add_n,
    input  logic [STEP_W-1:0] done_n,
    input  logic [STEP_W-1:0] kill_n,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int SUM_W = CNT_W + STEP_W + 2;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic signed [SUM_W-1:0] sum;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        sum = signed'(SUM_W'(cnt_q)) + signed'(SUM_W'(add_n))
            - signed'(SUM_W'(done_n)) - signed'(SUM_W'(kill_n));
        if (sum < 0)
            cnt_d = '0;
        else if (sum > signed'(SUM_W'(CNT_MAX)))
            cnt_d = CNT_W'(CNT_MAX);
        else
            cnt_d = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R3 floor: a decrement larger than the count leaves zero
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (add_n == '0 && (int'(done_n) + int'(kill_n) > int'(cnt_q))) |=> (cnt_q == '0));
    // R3 ceiling: an increment past the top holds at the maximum
    a_r3_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (done_n == '0 && kill_n == '0 && (int'(cnt_q) + int'(add_n) > CNT_MAX))
        |=> (int'(cnt_q) == CNT_MAX));
endmodule

// File: rtl/fts_share_gate.sv
`timescale 1ns/1ps
module fts_share_gate
    import fts_pkg::*;
#(
    parameter int NT     = 4,
    parameter int CNT_W  = 7,
    parameter int QDEPTH = 64
) (
    input  logic [NT-1:0]            active,
    input  logic [NT-1:0][CNT_W-1:0] cnt,
    output logic [NT-1:0]            cap_ok,
    output share_mode_e              mode
);
    int n_act;
    int cap;

    always_comb begin
        n_act = int'($countones(active));
        cap = QDEPTH;
        for (int n = 1; n <= NT; n++)
            if (n_act == n) cap = QDEPTH / n;
        if (n_act == 0)      mode = MODE_IDLE;
        else if (n_act == 1) mode = MODE_SOLO;
        else                 mode = MODE_SHARED;
    end

    always_comb begin
        cap_ok = '0;
        unique case (mode)
            MODE_IDLE:   cap_ok = '0;
            MODE_SOLO:   cap_ok = '1;
            MODE_SHARED: begin
                for (int i = 0; i < NT; i++)
                    cap_ok[i] = (int'(cnt[i]) < cap);
            end
            default:     cap_ok = '0;
        endcase
    end
endmodule

// File: rtl/fts_min_pick.sv
`timescale 1ns/1ps
module fts_min_pick #(
    parameter int NT    = 4,
    parameter int CNT_W = 7,
    localparam int PW   = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NT-1:0]            elig,
    input  logic [NT-1:0][CNT_W-1:0] cnt,
    input  logic [PW-1:0]            start,
    output logic [NT-1:0]            grant,
    output logic                     valid,
    output logic [PW-1:0]            win
);
    int best;

    always_comb begin
        best = -1;
        for (int k = 0; k < NT; k++) begin
            int j;
            j = int'(start) + k;
            if (j >= NT) j = j - NT;
            if (elig[j] && (best < 0 || cnt[j] < cnt[best])) best = j;
        end
        valid = (best >= 0);
        grant = '0;
        win   = '0;
        if (best >= 0) begin
            grant[best] = 1'b1;
            win = PW'(best);
        end
    end

    logic [CNT_W-1:0] win_cnt;
    assign win_cnt = cnt[win];

    generate
        for (genvar g = 0; g < NT; g++) begin : g_min_chk
            // R4: the winner's count is no larger than any eligible count
            a_r4_minimum: assert property (@(posedge clk) disable iff (!rst_n)
                (valid && elig[g]) |-> (win_cnt <= cnt[g]));
        end
    endgenerate
endmodule

// File: rtl/fts_fetch_sel.sv
`timescale 1ns/1ps
module fts_fetch_sel
    import fts_pkg::*;
#(
    parameter int NT     = 4,
    parameter int CNT_W  = 7,
    parameter int STEP_W = 3,
    parameter int QDEPTH = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NT*STEP_W-1:0] fetch_cnt,
    input  logic [NT*STEP_W-1:0] commit_cnt,
    input  logic [NT*STEP_W-1:0] squash_cnt,
    input  logic [NT-1:0]        thread_active,
    input  logic [NT-1:0]        thread_stalled,
    output logic [NT-1:0]        fetch_grant,
    output logic                 fetch_grant_valid
);
    localparam int PW = (NT > 1) ? $clog2(NT) : 1;

    logic [NT-1:0][CNT_W-1:0] cnt;
    logic [NT-1:0]            cap_ok, elig;
    logic [PW-1:0]            ptr_q, win;
    share_mode_e              mode;

    generate
        for (genvar t = 0; t < NT; t++) begin : g_ctr
            fts_inflight_ctr #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_ctr (
                .clk    (clk),
                .rst_n  (rst_n),
                .add_n  (fetch_cnt [t*STEP_W +: STEP_W]),
                .done_n (commit_cnt[t*STEP_W +: STEP_W]),
                .kill_n (squash_cnt[t*STEP_W +: STEP_W]),
                .cnt_o  (cnt[t])
            );
        end
    endgenerate

    fts_share_gate #(.NT(NT), .CNT_W(CNT_W), .QDEPTH(QDEPTH)) u_gate (
        .active (thread_active),
        .cnt    (cnt),
        .cap_ok (cap_ok),
        .mode   (mode)
    );

    assign elig = thread_active & ~thread_stalled & cap_ok;

    fts_min_pick #(.NT(NT), .CNT_W(CNT_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .cnt   (cnt),
        .start (ptr_q),
        .grant (fetch_grant),
        .valid (fetch_grant_valid),
        .win   (win)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (fetch_grant_valid)
            ptr_q <= (int'(win) == NT - 1) ? '0 : PW'(int'(win) + 1);
    end

    // Checker-side views derived from the ports and counters
    int n_act_chk;
    logic [CNT_W-1:0] gcnt;
    always_comb begin
        n_act_chk = int'($countones(thread_active));
        gcnt = '0;
        for (int i = 0; i < NT; i++)
            if (fetch_grant[i]) gcnt = cnt[i];
    end

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_grant));
    a_r10_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant_valid == (fetch_grant != '0));
    a_r6_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant_valid |-> ((fetch_grant & thread_active & ~thread_stalled) == fetch_grant));
    a_r9_none: assert property (@(posedge clk) disable iff (!rst_n)
        ((thread_active & ~thread_stalled) == '0) |-> !fetch_grant_valid);
    a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_grant_valid && mode == MODE_SHARED) |-> ((int'(gcnt) + 1) * n_act_chk <= QDEPTH));
    a_r8_solo: assert property (@(posedge clk) disable iff (!rst_n)
        (n_act_chk == 1 && (thread_active & ~thread_stalled) != '0) |-> fetch_grant_valid);
endmodule

// File: tb/tb_fts_fetch_sel.sv
`timescale 1ns/1ps
module tb_fts_fetch_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] fetch_cnt = '0, commit_cnt = '0, squash_cnt = '0;
    logic [3:0]  thread_active = '0, thread_stalled = '0;
    logic [3:0]  fetch_grant;
    logic        fetch_grant_valid;

    fts_fetch_sel dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_cnt(fetch_cnt), .commit_cnt(commit_cnt), .squash_cnt(squash_cnt),
        .thread_active(thread_active), .thread_stalled(thread_stalled),
        .fetch_grant(fetch_grant), .fetch_grant_valid(fetch_grant_valid)
    );

    always #4 clk = ~clk;

    int total = 0, bad = 0;
    bit done = 0;
    string tag = "R1";
    int m_cnt[4];
    int m_ptr = 0;
    int f[4], c[4], s[4];
    bit act[4], stl[4];

    function automatic int pick();
        int nact = 0, best = -1;
        for (int i = 0; i < 4; i++) nact += act[i];
        for (int k = 0; k < 4; k++) begin
            int j = (m_ptr + k) % 4;
            bit ok = act[j] && !stl[j] && (nact < 2 || m_cnt[j] < 64 / nact);
            if (ok && (best < 0 || m_cnt[j] < m_cnt[best])) best = j;
        end
        return best;
    endfunction

    task automatic clear_steps();
        for (int i = 0; i < 4; i++) begin f[i] = 0; c[i] = 0; s[i] = 0; end
    endtask

    task automatic set_act(input bit [3:0] a, input bit [3:0] st);
        for (int i = 0; i < 4; i++) begin act[i] = a[i]; stl[i] = st[i]; end
    endtask

    // Drive at the falling edge, compare before the rising edge, update the model at it
    task automatic cycle();
        int best;
        logic [3:0] eg;
        for (int i = 0; i < 4; i++) begin
            fetch_cnt[i*3 +: 3]  = 3'(f[i]);
            commit_cnt[i*3 +: 3] = 3'(c[i]);
            squash_cnt[i*3 +: 3] = 3'(s[i]);
            thread_active[i]  = act[i];
            thread_stalled[i] = stl[i];
        end
        #2;
        best = pick();
        eg = (best >= 0) ? 4'(1 << best) : 4'b0;
        total++;
        if (fetch_grant !== eg || fetch_grant_valid !== (best >= 0)) begin
            bad++;
            $display("FAIL %s t=%0t grant=%b valid=%b expected grant=%b valid=%b",
                     tag, $time, fetch_grant, fetch_grant_valid, eg, best >= 0);
        end
        @(posedge clk);
        if (rst_n) begin
            for (int i = 0; i < 4; i++) begin
                int v = m_cnt[i] + f[i] - c[i] - s[i];
                m_cnt[i] = (v < 0) ? 0 : (v > 127 ? 127 : v);
            end
            if (best >= 0) m_ptr = (best + 1) % 4;
        end
        @(negedge clk);
    endtask

    // Fetch n instructions on whichever thread the model grants
    task automatic fetch_on_grant(input int n, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            int g;
            clear_steps();
            g = pick();
            if (g >= 0) f[g] = n;
            cycle();
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        clear_steps();
        @(negedge clk);
        // R9 during reset: nothing active, no grant
        tag = "R9";
        set_act(4'b0000, 4'b0000);
        cycle();
        rst_n = 1'b1;
        // R1: all active after reset, thread 0 first
        tag = "R1";
        set_act(4'b1111, 4'b0000);
        cycle();
        // R5: equal counts rotate
        tag = "R5";
        for (int k = 0; k < 6; k++) cycle();
        // R2: counts diverge by fetch on the granted thread
        tag = "R2";
        fetch_on_grant(2, 6);
        clear_steps();
        f[1] = 3; c[1] = 1; s[2] = 1;
        cycle();
        // R4: minimum count wins
        tag = "R4";
        fetch_on_grant(1, 8);
        // R6: stall and deactivate threads
        tag = "R6";
        set_act(4'b1011, 4'b0001);
        fetch_on_grant(3, 6);
        set_act(4'b1111, 4'b0110);
        fetch_on_grant(3, 4);
        // R7: fill to the cap with four active threads until nothing is eligible
        tag = "R7";
        set_act(4'b1111, 4'b0000);
        fetch_on_grant(7, 14);
        // R9: all at or above the cap
        tag = "R9";
        clear_steps();
        cycle();
        cycle();
        // R8: only thread 0 active, no cap
        tag = "R8";
        set_act(4'b0001, 4'b0000);
        fetch_on_grant(7, 20);
        // R3 ceiling: thread 0 saturates at 127, then shares with thread 1
        tag = "R3";
        clear_steps();
        f[0] = 7;
        for (int k = 0; k < 4; k++) cycle();
        set_act(4'b0011, 4'b0000);
        for (int k = 0; k < 12; k++) begin
            clear_steps();
            c[0] = 7; s[0] = 7;
            cycle();
        end
        // R3 floor: over-drain every thread
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 4; i++) begin c[i] = 7; s[i] = 7; f[i] = 0; end
            cycle();
        end
        set_act(4'b1111, 4'b0000);
        clear_steps();
        cycle();
        // R4: random traffic
        tag = "R4";
        for (int k = 0; k < 3000; k++) begin
            int g;
            clear_steps();
            for (int i = 0; i < 4; i++) begin
                act[i] = ($urandom_range(0, 9) != 0);
                stl[i] = ($urandom_range(0, 3) == 0);
                c[i] = $urandom_range(0, 2);
                s[i] = ($urandom_range(0, 15) == 0) ? $urandom_range(0, 7) : 0;
            end
            g = pick();
            if (g >= 0) f[g] = $urandom_range(1, 7);
            cycle();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule